// File: doc/BRIEF.md
# Tagged Receive Byte Buffer with Idle Timeout

This block sits between the byte deserializer of a fixed 8N1 serial receiver and the processor. Every received byte arrives with two flags: a framing-error flag and a break flag. The byte and both flags are stored together in a 64-entry first-in first-out buffer. The processor drains the buffer through one 32-bit read word. That word always shows the oldest entry, and a one-cycle read strobe pops it.

The block reports its fill level. It raises a receive request while the level is at or above a threshold chosen from six steps. It raises a separate idle request when data has waited for a chosen number of character times without any byte arriving and without any pop. A byte that arrives when the buffer is full is lost, and a sticky overrun flag records the loss.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset the level is 0, the read word is 0x00000100, and rx_req, idle_req and overrun are all low.
- R2: Entries leave in arrival order. A read word for a stored entry carries the data in bits 7:0, the framing-error flag in bit 9 and the break flag in bit 10. Bit 8 and bits 31:11 are zero.
- R3: When the buffer is empty, the read word is 0x00000100 (bit 8 set, every other bit zero). A read strobe in that state leaves the level unchanged.
- R4: The level rises by one for each accepted byte and falls by one for each pop of a stored entry. It holds at most 64 entries. A push and a pop in the same cycle leave the level unchanged.
- R5: A byte that arrives when the level is 64 and no pop occurs in that cycle is dropped, and the stored contents are kept. The overrun output goes high on the next cycle and stays high until ovr_clr is strobed. If a new drop and ovr_clr fall in the same cycle, the drop wins.
- R6: rx_req is high in exactly those cycles where the level is at or above the threshold that trig_sel selects: code 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 16, 4 selects 32 and 5 selects 48. Codes 6 and 7 also select 48.
- R7: idle_tmo_sel code 0 disables idle_req. Codes 1, 2 and 3 raise idle_req once 4, 8 or 16 char_tick pulses have been counted while the level was nonzero.
- R8: The idle count restarts on every accepted byte and on every pop of a stored entry. It is held at zero while the buffer is empty, so idle_req is never high with the level at 0.
- R9: When the buffer is full, a byte that arrives in the same cycle as a pop is accepted. The level stays at 64 and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_frame_err | input | 1 | Framing error seen on this byte |
| in_break | input | 1 | Byte was part of a break condition |
| rd_en | input | 1 | Pop strobe for the oldest entry |
| rd_word | output | 32 | Oldest entry with its tags, or the empty indication |
| level | output | 7 | Number of stored entries |
| trig_sel | input | 3 | Receive request threshold code |
| idle_tmo_sel | input | 2 | Idle timeout code |
| char_tick | input | 1 | One pulse per character time |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rx_req | output | 1 | Level at or above threshold |
| idle_req | output | 1 | Data waiting past the idle limit |
| overrun | output | 1 | Sticky flag: a byte was lost |

## Verification
Directed fills to capacity and past it separate a correct drop, which leaves the level and contents alone, from a design that overwrites or wraps. A same-cycle push and pop at full exposes a design that counts that byte as an overrun. Sweeping each trigger code across a rising and falling level shows any wrong threshold step. Tick sequences with a push or pop placed just before the limit separate a counter that restarts from one that keeps counting. Long random mixes of pushes, pops, empty reads, ticks and clears, run with random tags, check ordering and tag placement against a bench queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DEPTH = 64;
  localparam int unsigned RXQ_LVL_W = $clog2(RXQ_DEPTH + 1);
  localparam int unsigned RXQ_TMO_W = 5;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rxq_entry_t;

  // Receive request threshold selected by the trigger code.
  function automatic logic [RXQ_LVL_W-1:0] rxq_threshold(input logic [2:0] code);
    case (code)
      3'd0:    rxq_threshold = RXQ_LVL_W'(1);
      3'd1:    rxq_threshold = RXQ_LVL_W'(4);
      3'd2:    rxq_threshold = RXQ_LVL_W'(8);
      3'd3:    rxq_threshold = RXQ_LVL_W'(16);
      3'd4:    rxq_threshold = RXQ_LVL_W'(32);
      default: rxq_threshold = RXQ_LVL_W'(48);
    endcase
  endfunction

  // Idle limit in character times; code 0 means disabled.
  function automatic logic [RXQ_TMO_W-1:0] rxq_idle_limit(input logic [1:0] code);
    rxq_idle_limit = RXQ_TMO_W'(2) << code;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  rxq_entry_t   wr_entry,
  input  logic         pop_req,
  output rxq_entry_t   head,
  output logic         empty,
  output logic         push_ok,
  output logic         pop_ok,
  output logic         drop,
  output logic [LW-1:0] count
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full;

  assign empty   = (count == '0);
  assign full    = (count == LW'(DEPTH));
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && !push_ok;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));
  a_r5_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> count == LW'(DEPTH));
  a_r3_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push) |=> empty);
  a_r9_full_pushpop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop_req) |=> full);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       activity,
  input  logic       has_data,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       expired
);
  logic [RXQ_TMO_W-1:0] cnt;
  logic [RXQ_TMO_W-1:0] limit;
  logic                 at_cap;

  assign limit   = rxq_idle_limit(sel);
  assign at_cap  = (cnt >= RXQ_TMO_W'(16));
  assign expired = has_data && (sel != 2'd0) && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (activity)          cnt <= '0;
    else if (!has_data)         cnt <= '0;
    else if (tick && !at_cap)   cnt <= cnt + 1'b1;
  end

  a_r8_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data |-> !expired);
  a_r8_restart_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> cnt == '0);
  a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |-> !expired);
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_frame_err,
  input  logic          in_break,
  input  logic          rd_en,
  output logic [31:0]   rd_word,
  output logic [LW-1:0] level,
  input  logic [2:0]    trig_sel,
  input  logic [1:0]    idle_tmo_sel,
  input  logic          char_tick,
  input  logic          ovr_clr,
  output logic          rx_req,
  output logic          idle_req,
  output logic          overrun
);
  rxq_entry_t wr_entry, head;
  logic       empty, push_ok, pop_ok, drop_evt;
  logic       ovr_q;

  assign wr_entry = '{brk: in_break, ferr: in_frame_err, data: in_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n,
    .push(in_valid), .wr_entry, .pop_req(rd_en),
    .head, .empty, .push_ok, .pop_ok, .drop(drop_evt), .count(level)
  );

  rxq_idle_timer u_idle (
    .clk, .rst_n,
    .activity(push_ok || pop_ok), .has_data(!empty),
    .tick(char_tick), .sel(idle_tmo_sel), .expired(idle_req)
  );

  assign rd_word = empty ? 32'h0000_0100
                         : {21'd0, head.brk, head.ferr, 1'b0, head.data};
  assign rx_req  = (level >= LW'(rxq_threshold(trig_sel)));

  always_ff @(posedge clk) begin
    if (!rst_n)        ovr_q <= 1'b0;
    else if (drop_evt) ovr_q <= 1'b1;
    else if (ovr_clr)  ovr_q <= 1'b0;
  end
  assign overrun = ovr_q;

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
  a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun);
  a_r6_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> level != '0);
  a_r2_tag_bit8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> rd_word[8] == 1'b0);
endmodule

// File: tb/rxq_tagged_fifo_bench.sv
module rxq_tagged_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_frame_err, in_break, rd_en, char_tick, ovr_clr;
  logic [7:0]  in_data;
  logic [2:0]  trig_sel;
  logic [1:0]  idle_tmo_sel;
  logic [31:0] rd_word;
  logic [6:0]  level;
  logic        rx_req, idle_req, overrun;

  int checks = 0, errors = 0;
  logic [9:0] q[$];
  int  m_cnt;
  bit  m_ovr;
  bit  done = 0;

  always #10 clk = ~clk;

  rxq_tagged_fifo u_rxq_tagged_fifo (
    .clk, .rst_n, .in_valid, .in_data, .in_frame_err, .in_break, .rd_en,
    .rd_word, .level, .trig_sel, .idle_tmo_sel, .char_tick, .ovr_clr,
    .rx_req, .idle_req, .overrun
  );

  function automatic int thr_of(int code);
    int t [8] = '{1, 4, 8, 16, 32, 48, 48, 48};
    return t[code];
  endfunction
  function automatic int lim_of(int code);
    return (code == 0) ? 0 : 4 * (1 << (code - 1));
  endfunction
  function automatic logic [31:0] word_of(logic [9:0] e);
    return {21'd0, e[9], e[8], 1'b0, e[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    int lv = q.size();
    chk("R4 level", 32'(level), 32'(lv));
    chk("R2/R3 rd_word", rd_word, (lv == 0) ? 32'h100 : word_of(q[0]));
    chk("R6 rx_req", 32'(rx_req), 32'(lv >= thr_of(int'(trig_sel))));
    chk("R7/R8 idle_req", 32'(idle_req),
        32'(lv != 0 && idle_tmo_sel != 0 && m_cnt >= lim_of(int'(idle_tmo_sel))));
    chk("R5 overrun", 32'(overrun), 32'(m_ovr));
  endtask

  // One cycle: drive at negedge, update model at the edge, check after it.
  task automatic step(bit push, logic [7:0] d, bit fe, bit bk, bit pop,
                      bit tick, bit clr);
    bit pop_ok, push_ok;
    in_valid = push; in_data = d; in_frame_err = fe; in_break = bk;
    rd_en = pop; char_tick = tick; ovr_clr = clr;
    @(posedge clk);
    pop_ok  = pop && q.size() != 0;
    push_ok = push && (q.size() < 64 || pop_ok);
    if (push_ok || pop_ok || q.size() == 0) m_cnt = 0;
    else if (tick && m_cnt < 16) m_cnt++;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back({bk, fe, d});
    if (push && !push_ok) m_ovr = 1;
    else if (clr) m_ovr = 0;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; in_valid = 0; in_data = 0; in_frame_err = 0; in_break = 0;
    rd_en = 0; char_tick = 0; ovr_clr = 0; trig_sel = 0; idle_tmo_sel = 0;
    m_cnt = 0; m_ovr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 level", 32'(level), 0);
    chk("R1 rd_word", rd_word, 32'h100);
    chk("R1 reqs", {29'd0, rx_req, idle_req, overrun}, 0);

    // R3 empty read leaves level alone
    step(0, 0, 0, 0, 1, 0, 0);
    // R2 tag placement
    step(1, 8'hA5, 1, 0, 0, 0, 0);
    step(1, 8'h3C, 0, 1, 0, 0, 0);
    step(1, 8'hFF, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0, 0);

    // R5/R9 fill past capacity, push+pop at full, clear
    trig_sel = 3'd5;
    for (int i = 0; i < 70; i++) step(1, 8'(i), i[0], i[1], 0, 0, 0);
    step(1, 8'h77, 0, 0, 1, 0, 0);   // R9 accepted at full
    step(0, 0, 0, 0, 0, 0, 1);       // R5 clear
    step(1, 8'h88, 0, 0, 0, 0, 1);   // R5 drop beats clear
    step(0, 0, 0, 0, 0, 0, 1);
    // R6 sweep each code while draining
    for (int c = 0; c < 8; c++) begin
      trig_sel = 3'(c);
      step(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 0, 0);
    end
    while (q.size() > 0) step(0, 0, 0, 0, 1, 0, 0);

    // R7/R8 idle timeout per code, with restart near limit
    for (int c = 0; c < 4; c++) begin
      idle_tmo_sel = 2'(c);
      for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 1, 0);  // empty: no count
      step(1, 8'h11, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 0);
      step(1, 8'h22, 0, 0, 0, 0, 0);                          // restart
      for (int i = 0; i < 18; i++) step(0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 1, 0, 0);                              // pop restarts
      step(0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 1, 1, 0);
      idle(2);
    end

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        trig_sel = 3'($urandom_range(0, 7));
        idle_tmo_sel = 2'($urandom_range(0, 3));
      end
      step(($urandom_range(0, 99) < ((i / 1000) % 2 ? 70 : 40)),
           8'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 99) < 45), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 49) == 0));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule